// File: doc/BRIEF.md
# Sixteen-Bit Two-Operand Arithmetic and Logic Unit

This block is the execute stage of a small 16-bit processor. Each cycle it takes an operation code, a width select, a source value and a destination value, and produces the value to be written back to the destination. It also produces a write-back enable and the next carry, zero, negative and overflow flags. Operand fetch, address generation, memory traffic and instruction decode all sit outside the block. The result, the write enable and the next flags are combinational, so they are valid in the same cycle as the inputs.

The block keeps its own status register. At a rising clock edge it loads the next flags when the flag-update enable is high and the operation is one that affects flags. The carry held in that register is the carry-in for the add-with-carry, subtract-with-carry and decimal-add operations. Subtraction adds the destination to the inverted source plus a carry-in, so a set carry means that no borrow occurred. In byte mode only the low eight bits take part, and the result is zero-extended to 16 bits.

The ports are plain control and data pins. There is no valid/ready handshake, because the block accepts a new operation every cycle and has no state that could stall.

Top module: `alu16_twoop`

## Requirements
- R1: The operation codes on `op_sel` are 0 MOV, 1 ADD, 2 ADDC, 3 SUBC, 4 SUB, 5 CMP, 6 DADD, 7 BIT, 8 BIC, 9 BIS, 10 XOR and 11 AND. ADD gives dst+src and ADDC gives dst+src+C. C takes the carry out of the active width.
- R2: SUB gives dst+~src+1 and SUBC gives dst+~src+C. C is set when no borrow occurs, which is the carry out of the active width.
- R3: DADD adds src, dst and C as packed BCD digits. Any digit sum above 9 is corrected by adding 6 and carries into the next digit. C takes the carry out of the top digit of the active width.
- R4: MOV gives src, AND gives src&dst, BIS gives src|dst, BIC gives ~src&dst and XOR gives src^dst. Each of them raises `wr_en`.
- R5: CMP computes dst+~src+1 and BIT computes src&dst. Both set the flags in the same way as SUB and AND, and both hold `wr_en` low.
- R6: When `byte_mode` is 1, only bits 7:0 of the operands are used, `result[15:8]` is zero, and carry, sign and overflow are taken at bit 7 instead of bit 15.
- R7: For ADD, ADDC, SUB, SUBC and CMP, V is set on signed overflow at the active width. V is cleared for DADD and for the logical operations.
- R8: For every operation that affects flags, N equals the sign bit of the result and Z is set exactly when the result is zero.
- R9: For AND, BIT and XOR, C equals the inverse of Z.
- R10: MOV, BIS and BIC leave the flags unchanged. Codes 12 to 15 leave the flags unchanged, hold `wr_en` low and give a result of 0.
- R11: `status_q` holds C at bit 0, Z at bit 1, N at bit 2 and V at bit 8; every other bit reads 0. It resets to 0. At a rising edge it loads `next_flags` only when `flag_upd_en` is high and the operation affects flags; otherwise it holds its value.
- R12: `next_flags` is {V,N,Z,C} and is valid in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects byte width, 0 selects word width |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| flag_upd_en | input | 1 | Allows the status register to load at the next edge |
| result | output | 16 | Computed value, zero-extended in byte mode |
| wr_en | output | 1 | Destination write-back enable |
| next_flags | output | 4 | Next flags as {V,N,Z,C} |
| status_q | output | 16 | Registered status word |

## Verification
`result`, `wr_en` and `next_flags` follow the inputs with no register in between. The bench therefore drives each operation on a falling edge and samples these outputs one nanosecond later, in the same cycle. `status_q` changes only at the next rising edge, so it is checked on the falling edge that follows. Each table vector first sets the carry with a flag-updating operation, waits one edge, and then applies the vector with updates disabled. In this way the stored carry that feeds ADDC, SUBC and DADD is known before the result is sampled.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_SUB  = 4'd4,
    OP_CMP  = 4'd5,
    OP_DADD = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_AND  = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

  localparam int STAT_C = 0;
  localparam int STAT_Z = 1;
  localparam int STAT_N = 2;
  localparam int STAT_V = 8;
endpackage

// File: rtl/alu16_bin_adder.sv
module alu16_bin_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         byte_mode,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int HALF = W / 2;

  logic [W:0]    full_sum;
  logic [HALF:0] low_sum;

  assign full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign low_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};

  always_comb begin
    if (byte_mode) begin
      sum  = {{(W-HALF){1'b0}}, low_sum[HALF-1:0]};
      cout = low_sum[HALF];
      ovf  = (a[HALF-1] == b[HALF-1]) && (low_sum[HALF-1] != a[HALF-1]);
    end else begin
      sum  = full_sum[W-1:0];
      cout = full_sum[W];
      ovf  = (a[W-1] == b[W-1]) && (full_sum[W-1] != a[W-1]);
    end
  end
endmodule

// File: rtl/alu16_bcd_adder.sv
module alu16_bcd_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         byte_mode,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int DIGITS = W / 4;
  localparam int HALF   = W / 2;

  logic [DIGITS:0] carry;
  logic [W-1:0]    raw_sum;

  assign carry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] nib_sum;
    logic       over9;
    logic [4:0] fixed;
    assign nib_sum = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0000, carry[g]};
    assign over9   = nib_sum > 5'd9;
    assign fixed   = over9 ? nib_sum + 5'd6 : nib_sum;
    assign raw_sum[4*g +: 4] = fixed[3:0];
    assign carry[g+1] = over9;
  end

  assign sum  = byte_mode ? {{(W-HALF){1'b0}}, raw_sum[HALF-1:0]} : raw_sum;
  assign cout = byte_mode ? carry[DIGITS/2] : carry[DIGITS];
endmodule

// File: rtl/alu16_status_reg.sv
module alu16_status_reg
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  alu_flags_t   flags_in,
  output logic [W-1:0] status
);
  alu_flags_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= flags_in;
  end

  always_comb begin
    status         = '0;
    status[STAT_C] = held.c;
    status[STAT_Z] = held.z;
    status[STAT_N] = held.n;
    status[STAT_V] = held.v;
  end
endmodule

// File: rtl/alu16_twoop.sv
module alu16_twoop
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic          byte_mode,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic          flag_upd_en,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [3:0]    next_flags,
  output logic [DW-1:0] status_q
);
  localparam int HALF = DW / 2;

  alu_op_e      op;
  alu_flags_t   cur, nxt;
  logic [DW-1:0] add_b, add_sum, bcd_sum;
  logic          add_cin, add_cout, add_ovf, bcd_cout;
  logic          touches;
  logic [DW-1:0] res_fit;
  logic [DW-1:0] logic_raw;

  assign op    = alu_op_e'(op_sel);
  assign cur.c = status_q[STAT_C];
  assign cur.z = status_q[STAT_Z];
  assign cur.n = status_q[STAT_N];
  assign cur.v = status_q[STAT_V];

  always_comb begin
    add_b   = src;
    add_cin = 1'b0;
    case (op)
      OP_ADDC:        add_cin = cur.c;
      OP_SUB, OP_CMP: begin add_b = ~src; add_cin = 1'b1; end
      OP_SUBC:        begin add_b = ~src; add_cin = cur.c; end
      default: ;
    endcase
  end

  alu16_bin_adder #(.W(DW)) u_bin (
    .a(dst), .b(add_b), .cin(add_cin), .byte_mode(byte_mode),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu16_bcd_adder #(.W(DW)) u_bcd (
    .a(dst), .b(src), .cin(cur.c), .byte_mode(byte_mode),
    .sum(bcd_sum), .cout(bcd_cout)
  );

  always_comb begin
    logic_raw = '0;
    case (op)
      OP_MOV:         logic_raw = src;
      OP_AND, OP_BIT: logic_raw = src & dst;
      OP_BIS:         logic_raw = src | dst;
      OP_BIC:         logic_raw = ~src & dst;
      OP_XOR:         logic_raw = src ^ dst;
      default:        logic_raw = '0;
    endcase
  end

  always_comb begin
    res_fit = '0;
    wr_en   = 1'b0;
    touches = 1'b0;
    nxt     = cur;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res_fit = add_sum;
        wr_en   = (op != OP_CMP);
        touches = 1'b1;
        nxt.c   = add_cout;
        nxt.v   = add_ovf;
      end
      OP_DADD: begin
        res_fit = bcd_sum;
        wr_en   = 1'b1;
        touches = 1'b1;
        nxt.c   = bcd_cout;
        nxt.v   = 1'b0;
      end
      OP_AND, OP_BIT, OP_XOR: begin
        res_fit = byte_mode ? {{(DW-HALF){1'b0}}, logic_raw[HALF-1:0]} : logic_raw;
        wr_en   = (op != OP_BIT);
        touches = 1'b1;
        nxt.c   = |res_fit;
        nxt.v   = 1'b0;
      end
      OP_MOV, OP_BIS, OP_BIC: begin
        res_fit = byte_mode ? {{(DW-HALF){1'b0}}, logic_raw[HALF-1:0]} : logic_raw;
        wr_en   = 1'b1;
      end
      default: ;
    endcase
    if (touches) begin
      nxt.z = (res_fit == '0);
      nxt.n = byte_mode ? res_fit[HALF-1] : res_fit[DW-1];
    end
  end

  assign result     = res_fit;
  assign next_flags = nxt;

  alu16_status_reg #(.W(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .load(flag_upd_en && touches),
    .flags_in(nxt), .status(status_q)
  );
endmodule

// File: rtl/alu16_twoop_chk.sv
module alu16_twoop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op_sel,
  input logic        byte_mode,
  input logic        flag_upd_en,
  input logic [15:0] result,
  input logic        wr_en,
  input logic [3:0]  next_flags,
  input logic [15:0] status_q
);
  logic flag_op;
  assign flag_op = (op_sel >= 4'd1 && op_sel <= 4'd7) || op_sel == 4'd10 || op_sel == 4'd11;

  a_r5_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd5 || op_sel == 4'd7) |-> !wr_en);

  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (result[15:8] == 8'h00));

  a_r8_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |-> (next_flags[1] == (result == 16'h0000)));

  a_r9_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd7 || op_sel == 4'd10 || op_sel == 4'd11) |->
      (next_flags[0] == !next_flags[1] && !next_flags[3]));

  a_r10_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 || op_sel == 4'd8 || op_sel == 4'd9 || op_sel >= 4'd12) |->
      (next_flags == {status_q[8], status_q[2], status_q[1], status_q[0]}));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd_en |=> $stable(status_q));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_en && flag_op) |=>
      ({status_q[8], status_q[2], status_q[1], status_q[0]} == $past(next_flags)));
endmodule

bind alu16_twoop alu16_twoop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .byte_mode(byte_mode),
  .flag_upd_en(flag_upd_en), .result(result), .wr_en(wr_en),
  .next_flags(next_flags), .status_q(status_q)
);

// File: tb/alu16_twoop_tb.sv
module alu16_twoop_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic        byte_mode;
  logic [15:0] src, dst;
  logic        flag_upd_en;
  logic [15:0] result;
  logic        wr_en;
  logic [3:0]  next_flags;
  logic [15:0] status_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu16_twoop u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .byte_mode(byte_mode),
    .src(src), .dst(dst), .flag_upd_en(flag_upd_en), .result(result),
    .wr_en(wr_en), .next_flags(next_flags), .status_q(status_q)
  );

  // op, byte, cin, src, dst, expected result, expected wr_en, expected {V,N,Z,C}
  localparam logic [58:0] VEC [0:20] = '{
    {4'd1,  1'b0, 1'b0, 16'h1234, 16'h4321, 16'h5555, 1'b1, 4'b0000}, // R1
    {4'd1,  1'b0, 1'b0, 16'h0001, 16'hFFFF, 16'h0000, 1'b1, 4'b0011}, // R1 carry out
    {4'd1,  1'b0, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 1'b1, 4'b1100}, // R7
    {4'd2,  1'b0, 1'b1, 16'h0001, 16'h0001, 16'h0003, 1'b1, 4'b0000}, // R1 ADDC
    {4'd1,  1'b1, 1'b0, 16'h00FF, 16'h1201, 16'h0000, 1'b1, 4'b0011}, // R6
    {4'd4,  1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0002, 1'b1, 4'b0001}, // R2
    {4'd4,  1'b0, 1'b0, 16'h0005, 16'h0003, 16'hFFFE, 1'b1, 4'b0100}, // R2 borrow
    {4'd3,  1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0001, 1'b1, 4'b0001}, // R2 SUBC
    {4'd4,  1'b0, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 4'b1001}, // R7 sub
    {4'd5,  1'b0, 1'b0, 16'h0007, 16'h0007, 16'h0000, 1'b0, 4'b0011}, // R5 CMP
    {4'd6,  1'b0, 1'b0, 16'h0766, 16'h1234, 16'h2000, 1'b1, 4'b0000}, // R3
    {4'd6,  1'b0, 1'b1, 16'h0000, 16'h9999, 16'h0000, 1'b1, 4'b0011}, // R3 carry
    {4'd6,  1'b1, 1'b0, 16'h0045, 16'hAB55, 16'h0000, 1'b1, 4'b0011}, // R3 byte
    {4'd11, 1'b0, 1'b0, 16'hF0F0, 16'h8F0F, 16'h8000, 1'b1, 4'b0101}, // R9 AND
    {4'd7,  1'b0, 1'b0, 16'h00F0, 16'h0F0F, 16'h0000, 1'b0, 4'b0010}, // R5 BIT
    {4'd10, 1'b1, 1'b0, 16'h0080, 16'h1200, 16'h0080, 1'b1, 4'b0101}, // R8 XOR byte
    {4'd9,  1'b0, 1'b1, 16'h0F00, 16'h00F0, 16'h0FF0, 1'b1, 4'b0011}, // R4 BIS
    {4'd8,  1'b0, 1'b0, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 4'b0010}, // R4 BIC
    {4'd0,  1'b1, 1'b1, 16'hABCD, 16'h0000, 16'h00CD, 1'b1, 4'b0011}, // R4 MOV byte
    {4'd12, 1'b0, 1'b0, 16'h1111, 16'h2222, 16'h0000, 1'b0, 4'b0010}, // R10 unused
    {4'd1,  1'b1, 1'b0, 16'h0040, 16'h0040, 16'h0080, 1'b1, 4'b1100}  // R7 byte
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic b, input logic [15:0] s,
                       input logic [15:0] d, input logic u);
    op_sel = o; byte_mode = b; src = s; dst = d; flag_upd_en = u;
  endtask

  // C=1 via SUB 0-0 (flags 0011), C=0 via ADD 0+0 (flags 0010)
  task automatic set_carry(input logic c);
    @(negedge clk);
    drive(c ? 4'd4 : 4'd1, 1'b0, 16'h0000, 16'h0000, 1'b1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(4'd0, 1'b0, 16'h0000, 16'h0000, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 reset status", {16'h0, status_q}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 21; i++) begin
      logic [58:0] v;
      v = VEC[i];
      set_carry(v[53]);
      drive(v[58:55], v[54], v[52:37], v[36:21], 1'b0);
      #1;
      check($sformatf("R12 vec%0d result", i), {16'h0, result}, {16'h0, v[20:5]});
      check($sformatf("R4 vec%0d wr_en", i), {31'h0, wr_en}, {31'h0, v[4]});
      check($sformatf("R8 vec%0d flags", i), {28'h0, next_flags}, {28'h0, v[3:0]});
    end

    // R11 load: 0x7FFF+1 sets V and N
    @(negedge clk);
    drive(4'd1, 1'b0, 16'h0001, 16'h7FFF, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R11 load V,N", {16'h0, status_q}, 32'h0104);
    // R11 hold with update disabled
    drive(4'd1, 1'b0, 16'h0001, 16'hFFFF, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R11 hold", {16'h0, status_q}, 32'h0104);
    // R10 MOV with update enabled leaves status
    drive(4'd0, 1'b0, 16'h0000, 16'h0000, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R10 MOV keeps status", {16'h0, status_q}, 32'h0104);
    // R5 CMP 3 vs 5 loads N with borrow
    drive(4'd5, 1'b0, 16'h0005, 16'h0003, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R5 CMP status", {16'h0, status_q}, 32'h0004);
    // R6 byte SUB borrow at bit 7: 0x10 - 0x20 = 0xF0, N=1, C=0
    drive(4'd4, 1'b1, 16'hFF20, 16'hAA10, 1'b0);
    #1;
    check("R6 byte sub result", {16'h0, result}, 32'h00F0);
    check("R6 byte sub flags", {28'h0, next_flags}, 32'h4);
    finish_run();
  end
endmodule